// File: doc/BRIEF.md
# Time-Multiplexed Multi-Target Echo Generator

This block synthesizes dechirped beat-signal samples for up to four simulated targets as seen by a 64-element receive array. Each target has a beat-frequency word, which sets how fast its phase turns from one sample to the next, and an element phase step, which sets the phase slope across the array. The four targets take turns on one shared datapath in round-robin slots. A single pipelined complex multiplier therefore rotates every target's tone by its element phase, and no target needs a multiplier of its own.

A start pulse launches a run. The block then sweeps every element for every target at each sample instant and repeats this for a fixed number of samples per chirp. A sequencing state machine walks through a list of four waveform types in fixed order. It moves to the next type after a programmable number of chirps and returns to the first type after the last one. Each output sample carries its element index, target index and waveform type, together with a valid flag.

Top module: `echo_tdm_gen`

## Requirements
- R1: After reset, out_valid is 0, and it stays 0 until start is sampled high.
- R2: The first valid sample appears on the 4th rising edge after the edge that samples start. From then on, out_valid is 1 on every cycle.
- R3: Slots are ordered with the target index innermost: t = slot count mod 4. Elements 0 to 63 form the outer loop. out_tgt and out_elem carry t and k.
- R4: Each target has a 32-bit phase accumulator. It is 0 for the first of the 4 samples in every chirp and advances by one step after each full sweep of 256 slots. Its bits [31:22] are the tone phase.
- R5: For element k, the element phase is (k * elem_step[t]) mod 2^16, and its bits [15:6] are the rotation phase. elem_step holds target t at bits [16t+15:16t], and beat_word holds target t at bits [32t+31:32t].
- R6: For a 10-bit phase p, S(p) = round(32000*sin(2*pi*p/1024)), with halves rounded away from zero, and C(p) = S((p+256) mod 1024).
- R7: With tone phase a and rotation phase e, out_i = (C(a)C(e) - S(a)S(e)) >>> 15 and out_q = (C(a)S(e) + S(a)C(e)) >>> 15. The shift is arithmetic and the result is kept as 16 bits signed.
- R8: The waveform code sets the accumulator step from the beat word f: 0 gives +f, 1 gives -f, 2 gives 0 (phase held), and 3 gives 2f, all modulo 2^32.
- R9: Waveform list entry i sits at wave_list[2i+1:2i] and is played in the order i = 0, 1, 2, 3, then back to 0. An entry lasts max(1, chirps_per_wave) chirps. out_wave shows the code in use for each sample.
- R10: A start pulse during a run restarts everything at list entry 0, sample 0, element 0, target 0. The first output of the new run appears with the R2 latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begins or restarts a run |
| wave_list | input | 8 | Four 2-bit waveform codes, played in order |
| chirps_per_wave | input | 8 | Number of chirps per waveform entry (0 is treated as 1) |
| beat_word | input | 128 | Beat-frequency word per target, 32 bits each |
| elem_step | input | 64 | Element phase step per target, 16 bits each |
| out_i | output | 16 | In-phase sample, signed |
| out_q | output | 16 | Quadrature sample, signed |
| out_elem | output | 6 | Element index of the sample |
| out_tgt | output | 2 | Target index of the sample |
| out_wave | output | 2 | Waveform code of the sample |
| out_valid | output | 1 | Sample valid |

## Verification
The hardest situation to reach is the return to the first waveform entry. It happens only after four entries, each lasting several chirps of 1024 slots, so it comes about 4000 to 9000 cycles after a start. It also coincides with the accumulators clearing, so a wrong step or an early clear is easy to miss. The stimulus holds each configuration long enough to cross that wrap: a zero chirp count, random chirp counts of 0 to 2 and random waveform lists. It then restarts in mid-stream, which forces a restart while old samples are still draining from the pipeline.

// File: rtl/echo_pkg.sv
package echo_pkg;

  typedef enum logic [1:0] {
    WV_UP     = 2'd0,
    WV_DOWN   = 2'd1,
    WV_HOLD   = 2'd2,
    WV_DOUBLE = 2'd3
  } wave_e;

  // One entry of a quarter-wave table, rounded to the nearest integer.
  function automatic int quarter_sine(input int idx, input int qlen, input int amp);
    real ang;
    ang = 1.5707963267948966 * real'(idx) / real'(qlen);
    return $rtoi(real'(amp) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/echo_tdm_seq.sv
module echo_tdm_seq
  import echo_pkg::*;
#(
  parameter int NT = 4,
  parameter int NE = 64,
  parameter int NS = 4,
  parameter int NW = 4,
  parameter int CW = 8,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1,
  localparam int EW = (NE > 1) ? $clog2(NE) : 1,
  localparam int SW = (NS > 1) ? $clog2(NS) : 1,
  localparam int WW = (NW > 1) ? $clog2(NW) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2*NW-1:0] wave_list,
  input  logic [CW-1:0]   chirps_per_wave,
  output logic            run,
  output logic [TW-1:0]   tgt,
  output logic [EW-1:0]   elem,
  output logic            elem_last,
  output logic            samp_first,
  output logic            samp_last,
  output wave_e           wave_code
);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e           state_q, state_d;
  logic [TW-1:0] tgt_q, tgt_d;
  logic [EW-1:0] elem_q, elem_d;
  logic [SW-1:0] samp_q, samp_d;
  logic [CW-1:0] chirp_q, chirp_d;
  logic [WW-1:0] widx_q, widx_d;

  logic tgt_last, widx_last, wave_due;

  assign tgt_last   = (tgt_q == TW'(NT - 1));
  assign elem_last  = (elem_q == EW'(NE - 1));
  assign samp_last  = (samp_q == SW'(NS - 1));
  assign samp_first = (samp_q == '0);
  assign widx_last  = (widx_q == WW'(NW - 1));
  assign wave_due   = (({1'b0, chirp_q} + 1'b1) >= {1'b0, chirps_per_wave});

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    elem_d  = elem_q;
    samp_d  = samp_q;
    chirp_d = chirp_q;
    widx_d  = widx_q;
    if (start) begin
      state_d = ST_RUN;
      tgt_d   = '0;
      elem_d  = '0;
      samp_d  = '0;
      chirp_d = '0;
      widx_d  = '0;
    end else if (state_q == ST_RUN) begin
      if (!tgt_last) begin
        tgt_d = tgt_q + 1'b1;
      end else begin
        tgt_d = '0;
        if (!elem_last) begin
          elem_d = elem_q + 1'b1;
        end else begin
          elem_d = '0;
          if (!samp_last) begin
            samp_d = samp_q + 1'b1;
          end else begin
            samp_d = '0;
            if (!wave_due) begin
              chirp_d = chirp_q + 1'b1;
            end else begin
              chirp_d = '0;
              widx_d  = widx_last ? '0 : widx_q + 1'b1;
            end
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tgt_q   <= '0;
      elem_q  <= '0;
      samp_q  <= '0;
      chirp_q <= '0;
      widx_q  <= '0;
    end else begin
      state_q <= state_d;
      tgt_q   <= tgt_d;
      elem_q  <= elem_d;
      samp_q  <= samp_d;
      chirp_q <= chirp_d;
      widx_q  <= widx_d;
    end
  end

  assign run       = (state_q == ST_RUN);
  assign tgt       = tgt_q;
  assign elem      = elem_q;
  assign wave_code = wave_e'(wave_list[{widx_q, 1'b0} +: 2]);

  // R9: the waveform entry only changes where a chirp begins
  p_wave_at_chirp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !$stable(widx_q) && !$past(start)) |-> (tgt_q == '0 && elem_q == '0 && samp_q == '0));

  // R3: the element index holds while the targets of one element are served
  p_elem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && !tgt_last) |=> $stable(elem_q));

endmodule

// File: rtl/echo_phase_bank.sv
module echo_phase_bank
  import echo_pkg::*;
#(
  parameter int NT     = 4,
  parameter int ACC_W  = 32,
  parameter int EPH_W  = 16,
  parameter int ADDR_W = 10,
  localparam int TW = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                run,
  input  logic [TW-1:0]       tgt,
  input  logic                elem_last,
  input  logic                samp_last,
  input  wave_e               wave_code,
  input  logic [NT*ACC_W-1:0] fw_flat,
  input  logic [NT*EPH_W-1:0] inc_flat,
  output logic [ADDR_W-1:0]   acc_addr,
  output logic [ADDR_W-1:0]   eph_addr
);

  logic [ACC_W-1:0] acc_arr [NT];
  logic [EPH_W-1:0] eph_arr [NT];

  for (genvar g = 0; g < NT; g++) begin : g_tgt
    logic [ACC_W-1:0] acc_q, acc_d, step, fw;
    logic [EPH_W-1:0] eph_q, eph_d, inc;
    logic             sel;

    assign fw  = fw_flat[g*ACC_W +: ACC_W];
    assign inc = inc_flat[g*EPH_W +: EPH_W];
    assign sel = run && (tgt == TW'(g));

    always_comb begin
      unique case (wave_code)
        WV_UP:     step = fw;
        WV_DOWN:   step = -fw;
        WV_HOLD:   step = '0;
        default:   step = {fw[ACC_W-2:0], 1'b0};
      endcase
    end

    always_comb begin
      acc_d = acc_q;
      eph_d = eph_q;
      if (start) begin
        acc_d = '0;
        eph_d = '0;
      end else if (sel) begin
        eph_d = elem_last ? '0 : eph_q + inc;
        if (elem_last) acc_d = samp_last ? '0 : acc_q + step;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc_q <= '0;
        eph_q <= '0;
      end else begin
        acc_q <= acc_d;
        eph_q <= eph_d;
      end
    end

    assign acc_arr[g] = acc_q;
    assign eph_arr[g] = eph_q;
  end

  logic [ACC_W-1:0] acc_sel;
  logic [EPH_W-1:0] eph_sel;

  assign acc_sel  = acc_arr[tgt];
  assign eph_sel  = eph_arr[tgt];
  assign acc_addr = acc_sel[ACC_W-1 -: ADDR_W];
  assign eph_addr = eph_sel[EPH_W-1 -: ADDR_W];

endmodule

// File: rtl/echo_sincos.sv
module echo_sincos
  import echo_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 16,
  parameter int AMP    = 32000,
  localparam int QLEN  = 1 << (ADDR_W - 2)
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic signed [SAMP_W-1:0] sin_o,
  output logic signed [SAMP_W-1:0] cos_o
);

  logic signed [SAMP_W-1:0] qrom [QLEN+1];

  for (genvar i = 0; i <= QLEN; i++) begin : g_q
    assign qrom[i] = SAMP_W'(quarter_sine(i, QLEN, AMP));
  end

  function automatic logic signed [SAMP_W-1:0] fold(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-2:0] ix;
    ix = a[ADDR_W-2] ? (ADDR_W-1)'(QLEN) - {1'b0, a[ADDR_W-3:0]}
                     : {1'b0, a[ADDR_W-3:0]};
    return a[ADDR_W-1] ? -qrom[ix] : qrom[ix];
  endfunction

  logic [ADDR_W-1:0] cos_addr;
  assign cos_addr = addr + ADDR_W'(QLEN);

  always_comb begin
    sin_o = fold(addr);
    cos_o = fold(cos_addr);
  end

endmodule

// File: rtl/echo_cplx_rot.sv
module echo_cplx_rot #(
  parameter int SAMP_W = 16,
  parameter int TAG_W  = 10,
  parameter int AMP    = 32000,
  localparam int PW    = 2 * SAMP_W,
  localparam int FRAC  = SAMP_W - 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     v_i,
  input  logic [TAG_W-1:0]         tag_i,
  input  logic signed [SAMP_W-1:0] si_i,
  input  logic signed [SAMP_W-1:0] sq_i,
  input  logic signed [SAMP_W-1:0] ri_i,
  input  logic signed [SAMP_W-1:0] rq_i,
  output logic                     v_o,
  output logic [TAG_W-1:0]         tag_o,
  output logic signed [SAMP_W-1:0] i_o,
  output logic signed [SAMP_W-1:0] q_o
);

  logic signed [PW-1:0] p_ii_q, p_qq_q, p_iq_q, p_qi_q;
  logic [TAG_W-1:0]     tag_m_q;
  logic                 v_m_q;
  logic signed [PW:0]   sum_i, sum_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_m_q   <= 1'b0;
      tag_m_q <= '0;
      p_ii_q  <= '0;
      p_qq_q  <= '0;
      p_iq_q  <= '0;
      p_qi_q  <= '0;
    end else begin
      v_m_q <= v_i;
      if (v_i) begin
        tag_m_q <= tag_i;
        p_ii_q  <= PW'(si_i) * PW'(ri_i);
        p_qq_q  <= PW'(sq_i) * PW'(rq_i);
        p_iq_q  <= PW'(si_i) * PW'(rq_i);
        p_qi_q  <= PW'(sq_i) * PW'(ri_i);
      end
    end
  end

  assign sum_i = (PW+1)'(p_ii_q) - (PW+1)'(p_qq_q);
  assign sum_q = (PW+1)'(p_iq_q) + (PW+1)'(p_qi_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_o   <= 1'b0;
      tag_o <= '0;
      i_o   <= '0;
      q_o   <= '0;
    end else begin
      v_o <= v_m_q;
      if (v_m_q) begin
        tag_o <= tag_m_q;
        i_o   <= SAMP_W'(sum_i >>> FRAC);
        q_o   <= SAMP_W'(sum_q >>> FRAC);
      end
    end
  end

  // R7: the rotated result of two unit-scale phasors stays inside the table amplitude
  p_mag_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
    v_o |-> (i_o <= SAMP_W'(AMP) && i_o >= -SAMP_W'(AMP) &&
             q_o <= SAMP_W'(AMP) && q_o >= -SAMP_W'(AMP)));

endmodule

// File: rtl/echo_tdm_gen.sv
module echo_tdm_gen
  import echo_pkg::*;
#(
  parameter int NT     = 4,
  parameter int NE     = 64,
  parameter int NS     = 4,
  parameter int NW     = 4,
  parameter int CW     = 8,
  parameter int ACC_W  = 32,
  parameter int EPH_W  = 16,
  parameter int ADDR_W = 10,
  parameter int SAMP_W = 16,
  parameter int AMP    = 32000,
  localparam int TW    = (NT > 1) ? $clog2(NT) : 1,
  localparam int EW    = (NE > 1) ? $clog2(NE) : 1,
  localparam int TAG_W = 2 + EW + TW
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [2*NW-1:0]          wave_list,
  input  logic [CW-1:0]            chirps_per_wave,
  input  logic [NT*ACC_W-1:0]      beat_word,
  input  logic [NT*EPH_W-1:0]      elem_step,
  output logic signed [SAMP_W-1:0] out_i,
  output logic signed [SAMP_W-1:0] out_q,
  output logic [EW-1:0]            out_elem,
  output logic [TW-1:0]            out_tgt,
  output logic [1:0]               out_wave,
  output logic                     out_valid
);

  logic          run, elem_last, samp_first, samp_last;
  logic [TW-1:0] tgt;
  logic [EW-1:0] elem;
  wave_e         wave_code;
  logic [ADDR_W-1:0] acc_addr, eph_addr;

  echo_tdm_seq #(.NT(NT), .NE(NE), .NS(NS), .NW(NW), .CW(CW)) u_seq (
    .clk, .rst_n, .start, .wave_list, .chirps_per_wave,
    .run, .tgt, .elem, .elem_last, .samp_first, .samp_last, .wave_code
  );

  echo_phase_bank #(.NT(NT), .ACC_W(ACC_W), .EPH_W(EPH_W), .ADDR_W(ADDR_W)) u_bank (
    .clk, .rst_n, .start, .run, .tgt, .elem_last, .samp_last, .wave_code,
    .fw_flat(beat_word), .inc_flat(elem_step), .acc_addr, .eph_addr
  );

  // Stage 1: latch the selected slot's phases and tag
  logic              v1_q;
  logic [ADDR_W-1:0] a1_q, e1_q;
  logic [TAG_W-1:0]  tag1_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q   <= 1'b0;
      a1_q   <= '0;
      e1_q   <= '0;
      tag1_q <= '0;
    end else begin
      v1_q <= run;
      if (run) begin
        a1_q   <= acc_addr;
        e1_q   <= eph_addr;
        tag1_q <= {wave_code, elem, tgt};
      end
    end
  end

  // Stage 2: table lookups for tone and element rotation
  logic signed [SAMP_W-1:0] s_sin, s_cos, r_sin, r_cos;
  logic signed [SAMP_W-1:0] si2_q, sq2_q, ri2_q, rq2_q;
  logic                     v2_q;
  logic [TAG_W-1:0]         tag2_q;

  echo_sincos #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .AMP(AMP)) u_tone (
    .addr(a1_q), .sin_o(s_sin), .cos_o(s_cos)
  );
  echo_sincos #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W), .AMP(AMP)) u_elem (
    .addr(e1_q), .sin_o(r_sin), .cos_o(r_cos)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v2_q   <= 1'b0;
      tag2_q <= '0;
      si2_q  <= '0;
      sq2_q  <= '0;
      ri2_q  <= '0;
      rq2_q  <= '0;
    end else begin
      v2_q <= v1_q;
      if (v1_q) begin
        tag2_q <= tag1_q;
        si2_q  <= s_cos;
        sq2_q  <= s_sin;
        ri2_q  <= r_cos;
        rq2_q  <= r_sin;
      end
    end
  end

  // Stages 3 and 4: the one shared complex multiplier
  logic [TAG_W-1:0] tag_o;

  echo_cplx_rot #(.SAMP_W(SAMP_W), .TAG_W(TAG_W), .AMP(AMP)) u_rot (
    .clk, .rst_n, .v_i(v2_q), .tag_i(tag2_q),
    .si_i(si2_q), .sq_i(sq2_q), .ri_i(ri2_q), .rq_i(rq2_q),
    .v_o(out_valid), .tag_o, .i_o(out_i), .q_o(out_q)
  );

  assign {out_wave, out_elem, out_tgt} = tag_o;

  // R2: every selected slot emerges exactly four edges later
  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(run, 4));

  // R5: element zero always rotates by zero phase
  p_eph_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && elem == '0) |-> (eph_addr == '0));

  // R4: the tone phase restarts at zero on the first sample of each chirp
  p_acc_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (run && samp_first) |-> (acc_addr == '0));

endmodule

// File: tb/echo_tdm_gen_tb.sv
`timescale 1ns/1ps
module echo_tdm_gen_tb;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, start;
  logic [7:0]  wave_list, chirps_per_wave;
  logic [127:0] beat_word;
  logic [63:0] elem_step;
  logic signed [15:0] out_i, out_q;
  logic [5:0]  out_elem;
  logic [1:0]  out_tgt, out_wave;
  logic        out_valid;

  logic [31:0] fw  [4];
  logic [15:0] inc [4];
  logic [1:0]  wl  [4];
  int          ncw;
  int          total = 0, bad = 0, j = 0;

  assign beat_word = {fw[3], fw[2], fw[1], fw[0]};
  assign elem_step = {inc[3], inc[2], inc[1], inc[0]};
  assign wave_list = {wl[3], wl[2], wl[1], wl[0]};
  assign chirps_per_wave = 8'(ncw);

  echo_tdm_gen u_dut (
    .clk, .rst_n, .start, .wave_list, .chirps_per_wave, .beat_word, .elem_step,
    .out_i, .out_q, .out_elem, .out_tgt, .out_wave, .out_valid
  );

  function automatic int sv(input int a);
    real x;
    x = $sin(6.283185307179586 * real'(a) / 1024.0) * 32000.0;
    if (x >= 0.0) return $rtoi(x + 0.5);
    return -$rtoi(-x + 0.5);
  endfunction

  function automatic int cv(input int a);
    return sv((a + 256) % 1024);
  endfunction

  function automatic void exp_slot(input int jj, output int ei, output int eq,
                                   output int ek, output int et, output int ew);
    int eff, n, c, a, e;
    logic [31:0] step, acc;
    logic [15:0] ep;
    longint si, sq, ri, rq, pi, pq;
    eff = (ncw == 0) ? 1 : ncw;
    et  = jj % 4;
    ek  = (jj / 4) % 64;
    n   = (jj / 256) % 4;
    c   = jj / 1024;
    ew  = int'(wl[(c / eff) % 4]);
    case (ew)
      0:       step = fw[et];
      1:       step = -fw[et];
      2:       step = 32'd0;
      default: step = fw[et] << 1;
    endcase
    acc = 32'(n) * step;
    a   = int'(acc[31:22]);
    ep  = 16'(ek) * inc[et];
    e   = int'(ep[15:6]);
    si = longint'(cv(a)); sq = longint'(sv(a));
    ri = longint'(cv(e)); rq = longint'(sv(e));
    pi = (si * ri - sq * rq) >>> 15;
    pq = (si * rq + sq * ri) >>> 15;
    ei = int'(pi);
    eq = int'(pq);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic watch(input int nout);
    int ei, eq, ek, et, ew;
    for (int i = 0; i < nout; i++) begin
      @(negedge clk);
      if (!out_valid) begin
        chk(1'b0, "R2", "valid gap", 0, 1);
      end else begin
        exp_slot(j, ei, eq, ek, et, ew);
        chk(int'(out_tgt) == et, "R3", "target tag", out_tgt, et);
        chk(int'(out_elem) == ek, "R3", "element tag", out_elem, ek);
        chk(int'(out_wave) == ew, "R9", "wave tag", out_wave, ew);
        chk(int'(out_i) == ei, "R4 R5 R6 R7 R8", "I sample", out_i, ei);
        chk(int'(out_q) == eq, "R4 R5 R6 R7 R8", "Q sample", out_q, eq);
      end
      j++;
    end
  endtask

  task automatic do_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    int eff;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; start = 1'b0; ncw = 1;
    for (int t = 0; t < 4; t++) begin fw[t] = '0; inc[t] = '0; wl[t] = 2'(t); end

    // R1: reset state
    repeat (4) @(negedge clk);
    chk(out_valid == 1'b0, "R1", "valid in reset", out_valid, 0);
    rst_n = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R1", "valid before start", out_valid, 0);
    end

    // Directed: zero frequency and zero element step, start from idle
    do_start();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(out_valid == 1'b0, "R2", "early valid", out_valid, 0);
    end
    @(negedge clk);
    chk(out_valid == 1'b1, "R2", "first valid", out_valid, 1);
    chk(int'(out_i) == 31250, "R6", "unit phasor I", out_i, 31250);
    chk(int'(out_q) == 0, "R6", "unit phasor Q", out_q, 0);
    j = 1;
    watch(299);

    // Directed: extreme words, reversed list, zero chirp count
    fw[0] = 32'hFFFF_FFFF; fw[1] = 32'h8000_0000; fw[2] = 32'h0040_0000; fw[3] = 32'h1234_5678;
    inc[0] = 16'h8000; inc[1] = 16'hFFFF; inc[2] = 16'h0040; inc[3] = 16'h0000;
    wl[0] = 2'd3; wl[1] = 2'd2; wl[2] = 2'd1; wl[3] = 2'd0; ncw = 0;
    do_start();
    repeat (3) @(negedge clk);
    j = 0;
    watch(4 * 1024 + 256);

    // Random configurations, each crossing the list wrap
    for (int r = 0; r < 3; r++) begin
      for (int t = 0; t < 4; t++) begin
        fw[t]  = $urandom();
        inc[t] = 16'($urandom());
        wl[t]  = 2'($urandom());
      end
      ncw = int'($urandom() % 3);
      eff = (ncw == 0) ? 1 : ncw;
      do_start();
      repeat (3) @(negedge clk);
      j = 0;
      watch(4 * eff * 1024 + 256);
    end

    // R10: restart in mid-stream
    watch(137);
    do_start();
    repeat (3) @(negedge clk);
    @(negedge clk);
    chk(out_valid && out_elem == 6'd0 && out_tgt == 2'd0, "R10", "restart slot",
        {out_valid, out_elem, out_tgt}, {1'b1, 8'd0});
    chk(int'(out_wave) == int'(wl[0]), "R10", "restart wave entry", out_wave, wl[0]);
    j = 1;
    watch(600);

    finish_run();
  end

endmodule